// File: doc/BRIEF.md
# PASID Command Register Unit

This unit sits on a simple 32-bit register port and lets software allocate and release process address space identifiers (PASIDs). Software writes a command word. The unit decodes it, updates a small pool of identifiers kept as a bitmap, and posts the outcome in a response register. The response carries a busy flag, a two-bit status code and, for an allocation, the granted identifier.

A capability register tells software whether allocation is supported. While a command is executing, the busy flag is high and new command writes are dropped. Software polls the response register until the busy flag is clear, then reads the status and the result. Identifier zero is reserved and is never granted. An allocation scans the pool one entry per clock and returns the lowest free identifier.

Top module: `pasid_cmd_regs`

## Requirements
- R1: After reset, the capability word at offset 0xE00 reads 0x00000001, and the command word (0xE10) and response word (0xE20) read zero.
- R2: Each register is 64 bits wide and is reached as two 32-bit halves at +0 and +4. The upper halves of the capability and response registers read zero. Writes to the capability and response registers have no effect.
- R3: An accepted command write sets response bit 0 (busy) and clears the status bits 2:1 and the result bits 27:8, so an earlier error code does not survive into the new command.
- R4: A write to either half of the command register is ignored, leaving that half unchanged and starting nothing, while busy is set or when capability bit 0 is clear.
- R5: Command bits 7:0 carry the opcode. Opcode 0 (null) completes on the next clock with status 0 and leaves the pool untouched.
- R6: Opcode 1 (allocate) marks the lowest free identifier at or above 1 as used. It returns that identifier in response bits 27:8 with status 0, and it never returns 0.
- R7: An allocate on a full pool completes with status 2 (none available) and result 0. Busy stays high while the scan advances one entry per clock.
- R8: Opcode 2 (free) releases the identifier held in command bits 27:8 and completes with status 0. A released identifier can be granted again.
- R9: A free of identifier 0, of one at or beyond the pool size, or of one not currently allocated completes with status 2 and leaves the pool unchanged.
- R10: Any opcode of 3 or above completes with status 1 (undefined command) and leaves the pool unchanged.
- R11: A write to the upper command half at 0xE14 is stored when the write guard allows it, but it starts no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the 32-bit half being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| bus_rvalid | output | 1 | High in the cycle that bus_rdata carries a read result |

## Verification
On every cycle, the assertions check the following:
- a blocked command write leaves the command halves unchanged;
- a start never lands on a busy unit;
- each accepted command begins with clean status and result fields;
- a null command ends after one clock, and an undefined opcode yields code 1;
- the pool never grants identifier 0, never grants an entry that is already used, and never releases an entry that is free.

Only the bench scenarios can show which identifier an allocation returns. The same goes for a freed identifier being granted again, the exhaustion code on a full pool, and a rejected free or bad opcode leaving the pool intact, which the bench observes through the identifier that the next allocation returns.

// File: rtl/pasid_cmd_pkg.sv
// Package: shared constants for the PASID command register unit.
// Assumes 32-bit register halves and a 12-bit byte offset space.
package pasid_cmd_pkg;

    localparam int          PASID_W     = 20;
    localparam int          ARG_LSB     = 8;

    localparam logic [11:0] OFS_CAP_LO  = 12'hE00;
    localparam logic [11:0] OFS_CAP_HI  = 12'hE04;
    localparam logic [11:0] OFS_CMD_LO  = 12'hE10;
    localparam logic [11:0] OFS_CMD_HI  = 12'hE14;
    localparam logic [11:0] OFS_RSP_LO  = 12'hE20;
    localparam logic [11:0] OFS_RSP_HI  = 12'hE24;

    localparam logic [7:0]  OP_NULL     = 8'd0;
    localparam logic [7:0]  OP_ALLOC    = 8'd1;
    localparam logic [7:0]  OP_FREE     = 8'd2;

    localparam logic [1:0]  ST_OK       = 2'd0;
    localparam logic [1:0]  ST_BADOP    = 2'd1;
    localparam logic [1:0]  ST_NOPASID  = 2'd2;

endpackage

// File: rtl/pasid_pool.sv
// Module: pasid_pool
// Holds one used-bit per identifier, with identifier n at bit n.
// It offers a combinational probe of a single entry, plus one set
// port and one clear port. It assumes the controller never sets and
// clears in the same cycle and never targets entry 0 for a set.
module pasid_pool #(
    parameter int NUM   = 64,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_free,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);

    logic [NUM-1:0] used;

    // Report whether the probed entry is free.
    assign probe_free = ~used[probe_idx];

    for (genvar i = 0; i < NUM; i++) begin : g_entry
        // Per-entry used bit: set on grant, cleared on release, all free after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used[i] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(i)) begin
                used[i] <= 1'b1;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
                used[i] <= 1'b0;
            end
        end
    end

    // R6: identifier 0 is never granted.
    assert_no_zero_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> set_idx != '0);

    // R6: a grant only targets a free entry.
    assert_grant_free_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !used[set_idx]);

    // R9: a release only targets an allocated entry.
    assert_release_used_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> used[clr_idx]);

    // R9: set and clear never collide.
    assert_no_set_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));

endmodule

// File: rtl/pasid_cmd_ctrl.sv
// Module: pasid_cmd_ctrl
// Executes one command at a time. It holds the busy flag, the status
// code and the result that make up the response. An allocation scans
// the pool one entry per clock, starting at 1. A free validates its
// argument before releasing. It assumes start is only raised while
// busy is low; the top gates it.
module pasid_cmd_ctrl
    import pasid_cmd_pkg::*;
#(
    parameter int NUM   = 64,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         op_in,
    input  logic [PASID_W-1:0] arg_in,
    output logic               busy,
    output logic [1:0]         status,
    output logic [PASID_W-1:0] result,
    output logic [IDX_W-1:0]   probe_idx,
    input  logic               probe_free,
    output logic               set_en,
    output logic [IDX_W-1:0]   set_idx,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx
);

    localparam logic [PASID_W-1:0] NUM_W    = PASID_W'(NUM);
    localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(NUM - 1);

    logic [7:0]         op_q;
    logic [PASID_W-1:0] arg_q;
    logic [IDX_W-1:0]   scan_q;
    logic               arg_ok;
    logic [IDX_W-1:0]   free_idx;

    // Check that the free argument is nonzero and inside the pool.
    assign arg_ok   = (arg_q != '0) && (arg_q < NUM_W);
    assign free_idx = arg_q[IDX_W-1:0];

    // Choose the probed entry and form the pool update requests.
    always_comb begin
        probe_idx = (op_q == OP_FREE) ? free_idx : scan_q;
        set_en    = busy && (op_q == OP_ALLOC) && probe_free;
        set_idx   = scan_q;
        clr_en    = busy && (op_q == OP_FREE) && arg_ok && !probe_free;
        clr_idx   = free_idx;
    end

    // Command sequencing: accept, step the scan, post the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            status <= ST_OK;
            result <= '0;
            op_q   <= OP_NULL;
            arg_q  <= '0;
            scan_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            status <= ST_OK;
            result <= '0;
            op_q   <= op_in;
            arg_q  <= arg_in;
            scan_q <= IDX_W'(1);
        end else if (busy) begin
            case (op_q)
                OP_NULL: busy <= 1'b0;
                OP_ALLOC: begin
                    if (probe_free) begin
                        result <= PASID_W'(scan_q);
                        busy   <= 1'b0;
                    end else if (scan_q == LAST_IDX) begin
                        status <= ST_NOPASID;
                        busy   <= 1'b0;
                    end else begin
                        scan_q <= scan_q + IDX_W'(1);
                    end
                end
                OP_FREE: begin
                    if (!(arg_ok && !probe_free)) begin
                        status <= ST_NOPASID;
                    end
                    busy <= 1'b0;
                end
                default: begin
                    status <= ST_BADOP;
                    busy   <= 1'b0;
                end
            endcase
        end
    end

    // R3: every accepted command starts with clean status and result.
    assert_accept_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (status == ST_OK) && (result == '0));

    // R4: a start never arrives while a command is running.
    assert_no_start_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R5: a null command finishes on the next clock.
    assert_null_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == OP_NULL) |=> !busy);

    // R6: a successful allocation never reports identifier 0.
    assert_alloc_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == OP_ALLOC && status == ST_OK) |-> result != '0);

    // R10: an undefined opcode ends with the undefined-command code.
    assert_badop_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q > OP_FREE) |=> (!busy && status == ST_BADOP));

endmodule

// File: rtl/pasid_cmd_regs.sv
// Module: pasid_cmd_regs (top)
// Register front end for the PASID command unit. It decodes 32-bit
// accesses to the capability, command and response halves and guards
// command writes with the capability bit and the busy flag. A write to
// the lower command half that passes the guard starts a command. Reads
// return one clock after the strobe.
module pasid_cmd_regs
    import pasid_cmd_pkg::*;
#(
    parameter int NUM_PASIDS      = 64,
    parameter bit CAP_PASID_ALLOC = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid
);

    localparam int IDX_W = $clog2(NUM_PASIDS);
    localparam int PAD_W = 32 - ARG_LSB - PASID_W;

    logic [31:0]        cmd_lo;
    logic [31:0]        cmd_hi;
    logic               busy;
    logic [1:0]         status;
    logic [PASID_W-1:0] result;
    logic [IDX_W-1:0]   probe_idx;
    logic               probe_free;
    logic               set_en;
    logic [IDX_W-1:0]   set_idx;
    logic               clr_en;
    logic [IDX_W-1:0]   clr_idx;
    logic               wr_lo;
    logic               wr_hi;
    logic               guard_ok;
    logic               start;
    logic [31:0]        rsp_lo;
    logic [31:0]        rd_mux;

    // Decode command writes and the guard that admits them.
    assign wr_lo    = bus_en && bus_we && (bus_addr == OFS_CMD_LO);
    assign wr_hi    = bus_en && bus_we && (bus_addr == OFS_CMD_HI);
    assign guard_ok = CAP_PASID_ALLOC && !busy;
    assign start    = wr_lo && guard_ok;

    // Pack the response word: result, status and busy.
    assign rsp_lo = {{PAD_W{1'b0}}, result, 5'b0, status, busy};

    // Hold the command halves; only guarded writes land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_lo <= '0;
            cmd_hi <= '0;
        end else begin
            if (start)            cmd_lo <= bus_wdata;
            if (wr_hi && guard_ok) cmd_hi <= bus_wdata;
        end
    end

    // Select the read data for the addressed half.
    always_comb begin
        case (bus_addr)
            OFS_CAP_LO: rd_mux = {31'b0, CAP_PASID_ALLOC};
            OFS_CMD_LO: rd_mux = cmd_lo;
            OFS_CMD_HI: rd_mux = cmd_hi;
            OFS_RSP_LO: rd_mux = rsp_lo;
            default:    rd_mux = '0;
        endcase
    end

    // Register the read return one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_en && !bus_we;
            if (bus_en && !bus_we) bus_rdata <= rd_mux;
        end
    end

    pasid_cmd_ctrl #(.NUM(NUM_PASIDS), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_in      (bus_wdata[7:0]),
        .arg_in     (bus_wdata[ARG_LSB +: PASID_W]),
        .busy       (busy),
        .status     (status),
        .result     (result),
        .probe_idx  (probe_idx),
        .probe_free (probe_free),
        .set_en     (set_en),
        .set_idx    (set_idx),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx)
    );

    pasid_pool #(.NUM(NUM_PASIDS), .IDX_W(IDX_W)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_idx  (probe_idx),
        .probe_free (probe_free),
        .set_en     (set_en),
        .set_idx    (set_idx),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx)
    );

    // R4: a blocked write to the lower command half leaves it unchanged.
    assert_blocked_lo_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && (busy || !CAP_PASID_ALLOC)) |=> $stable(cmd_lo));

    // R4 and R11: a blocked write to the upper command half leaves it unchanged.
    assert_blocked_hi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && (busy || !CAP_PASID_ALLOC)) |=> $stable(cmd_hi));

    // R11: an upper-half write never starts a command.
    assert_hi_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !busy) |=> !busy);

endmodule

// File: tb/pasid_cmd_regs_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for pasid_cmd_regs. Driver tasks queue the expected
// read data, and a monitor pops and compares each read return.
module pasid_cmd_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] nc_rdata;
    logic        nc_rvalid;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] last_rd = '0;
    bit          done = 1'b0;

    logic [31:0] exp_q[$];
    bit          chk_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pasid_cmd_regs u_pasid_cmd_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

    // Second instance with allocation support disabled; it shares the bus inputs.
    pasid_cmd_regs #(.CAP_PASID_ALLOC(1'b0)) u_nocap (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(nc_rdata), .bus_rvalid(nc_rvalid));

    // Monitor: pop one expectation per read return and compare it.
    always @(negedge clk) begin
        if (bus_rvalid && exp_q.size() > 0) begin
            logic [31:0] e;
            bit          c;
            string       t;
            e = exp_q.pop_front();
            c = chk_q.pop_front();
            t = tag_q.pop_front();
            last_rd = bus_rdata;
            if (c) begin
                n_cmp++;
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input bit c, input string t);
        exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(t);
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk); bus_en = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            rd(12'hE20, 32'h0, 1'b0, "poll");
            if (last_rd[0] == 1'b0) break;
        end
    endtask

    // Issue a command, wait until the unit is idle, then check the response.
    task automatic cmd(input logic [31:0] w, input logic [31:0] exp_rsp, input string t);
        wr(12'hE10, w);
        wait_idle();
        rd(12'hE20, exp_rsp, 1'b1, t);
    endtask

    // Read the capability-disabled instance and compare directly.
    task automatic nc_check(input logic [11:0] a, input logic [31:0] e, input string t);
        rd(a, 32'h0, 1'b0, "nocap");
        n_cmp++;
        if (nc_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", t, nc_rdata, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        rd(12'hE00, 32'h1, 1'b1, "R1 cap reset");
        rd(12'hE10, 32'h0, 1'b1, "R1 cmd reset");
        rd(12'hE20, 32'h0, 1'b1, "R1 rsp reset");
        // R2: upper halves read zero, read-only registers ignore writes
        rd(12'hE04, 32'h0, 1'b1, "R2 cap upper half");
        wr(12'hE00, 32'hFFFF_FFFF);
        wr(12'hE20, 32'h0000_00FF);
        rd(12'hE00, 32'h1, 1'b1, "R2 cap read-only");
        rd(12'hE20, 32'h0, 1'b1, "R2 rsp read-only");

        // R4: back-to-back write while busy is dropped
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'hE10; bus_wdata = 32'h0000_0500;
        @(negedge clk); bus_wdata = 32'h0000_0001;
        @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
        rd(12'hE10, 32'h0000_0500, 1'b1, "R4 cmd unchanged while busy");
        wait_idle();
        rd(12'hE20, 32'h0, 1'b1, "R5 null command status");

        // R6: lowest free identifier, and the dropped allocate had no effect
        cmd(32'h1, 32'h100, "R6 first alloc gives 1");
        cmd(32'h1, 32'h200, "R6 alloc gives 2");
        cmd(32'h1, 32'h300, "R6 alloc gives 3");

        // R8: free then regrant
        cmd(32'h0000_0202, 32'h0, "R8 free 2 ok");
        cmd(32'h1, 32'h200, "R8 freed 2 regranted");

        // R9: invalid frees
        cmd(32'h0000_0502, 32'h4, "R9 free unallocated 5");
        cmd(32'h0000_0002, 32'h4, "R9 free zero");
        cmd(32'h0000_4002, 32'h4, "R9 free out of range 64");
        cmd(32'h1, 32'h400, "R9 pool unchanged, alloc gives 4");

        // R10: undefined opcode
        cmd(32'h0000_0007, 32'h2, "R10 undefined opcode");
        cmd(32'h1, 32'h500, "R10 pool unchanged, alloc gives 5");

        // R3: a new command clears the old error and raises busy
        cmd(32'h0000_0002, 32'h4, "R3 setup error status");
        wr(12'hE10, 32'h1);
        rd(12'hE20, 32'h1, 1'b1, "R3 busy with cleared fields");
        wait_idle();
        rd(12'hE20, 32'h600, 1'b1, "R7 scan result 6");

        // R11: upper command half stores but starts nothing
        wr(12'hE14, 32'h0000_ABCD);
        rd(12'hE14, 32'h0000_ABCD, 1'b1, "R11 upper half stored");
        rd(12'hE20, 32'h600, 1'b1, "R11 no command started");
        rd(12'hE10, 32'h1, 1'b1, "R11 lower half unchanged");

        // R7: fill the pool, then exhaust it
        for (int k = 7; k < 64; k++) begin
            cmd(32'h1, 32'(k) << 8, "R6 fill alloc");
        end
        cmd(32'h1, 32'h4, "R7 pool full status 2");

        // R4: capability clear, so every command write was dropped
        nc_check(12'hE00, 32'h0, "R4 nocap capability");
        nc_check(12'hE10, 32'h0, "R4 nocap cmd unchanged");
        nc_check(12'hE20, 32'h0, "R4 nocap rsp idle");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule